// File: doc/BRIEF.md
# Two-Line Serial Command Packet Receiver

This block rebuilds a 128-bit command packet that a host sends one bit at a time. The host toggles two select lines of its joypad register, and every write of that register gives the block a 2-bit line value. Four values have meaning. 2'b00 restarts the packet. 2'b01 marks a one bit. 2'b11 is the bit clock. 2'b10 closes the packet once all bits are in. A value that matches the previous accepted value carries no information and is dropped. So only transitions move the decoder forward, with one exception: a restart acts every time it arrives.

When the packet is closed, the block raises a one-cycle strobe. The 16 assembled bytes stay on the data output until the next restart. The bit counter then parks above the packet length. From there the same line values drive a controller-switch handshake. The host sets two flags, one by the one-bit value and one by the close value, and then clocks. That step advances a controller index, which wraps under a controller-count mask.

The line input is a valid-qualified write without a ready signal. The receiver takes one value in any cycle and never applies back-pressure. The packet output is a strobe without a ready signal. A consumer that misses the strobe can still read the held data, because the data does not change until the next restart. The mask and the index are plain control pins.

Top module: `cmdpkt_rx`

## Requirements
- R1: After rst_n is released, pkt_valid is 0, ctrl_idx is 0 and pkt_data is all zero. The bit counter starts at -1, so a 2'b01 write before the first 2'b11 sets no bit. The previous-value register starts at 2'b11.
- R2: A write of 2'b00 clears pkt_data and sets the bit counter to -1. It does this even when the previous value was also 2'b00. It leaves ctrl_idx unchanged.
- R3: A nonzero write equal to the previous accepted line value has no effect.
- R4: When the counter n is in 0..127, a changed write of 2'b01 sets bit n of pkt_data. That is byte n>>3, bit n&7, and byte k sits on pkt_data[8k+7:8k].
- R5: A changed write of 2'b11 increments the counter while it is below 128. At 128 the counter stops, and 2'b01 and 2'b11 alter neither the counter nor pkt_data.
- R6: A changed write of 2'b10 with the counter at 128 raises pkt_valid for exactly one cycle, in the cycle after the write. No other write raises pkt_valid. pkt_data then holds until the next 2'b00.
- R7: Once the counter is above 128, 2'b01 sets counter bit 1 and 2'b10 sets counter bit 2. A 2'b11 with the counter at 135 clears both bits and sets ctrl_idx to (ctrl_idx+1) AND ctrl_mask.
- R8: A 2'b11 with the counter above 128 but not at 135 leaves ctrl_idx unchanged. No write during packet collection changes ctrl_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | A line value is written this cycle |
| line_val | input | 2 | Written select-line value |
| ctrl_mask | input | IDX_W (2) | Controller-count mask applied to the index step |
| pkt_data | output | PKT_BITS (128) | Assembled packet, byte k on bits 8k+7:8k |
| pkt_valid | output | 1 | One-cycle strobe: packet complete |
| ctrl_idx | output | IDX_W (2) | Current controller index |

## Verification
The assertions check the following on every cycle:
- the bit counter stays in its legal range of -1 to 135;
- a write that is neither a restart nor a change leaves the counter and the index unchanged;
- a restart always returns the counter to -1 and empties the buffer;
- the strobe never lasts longer than one cycle;
- the index moves only from the handshake state.

Only the bench scenarios can show what needs a full line sequence. That covers the exact packet contents for several bit patterns, the rejection of extra clocks and one-bits past bit 127, a single strobe per packet, and the index sequence under different masks, including handshakes given in the wrong order.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;
  localparam logic [1:0] LN_RESET = 2'b00;
  localparam logic [1:0] LN_ONE   = 2'b01;
  localparam logic [1:0] LN_CLOSE = 2'b10;
  localparam logic [1:0] LN_CLOCK = 2'b11;
endpackage

// File: rtl/cmdpkt_edge.sv
// Keeps the last accepted line value and turns writes into events.
module cmdpkt_edge
  import cmdpkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [1:0] wr_line,
  output logic       rst_ev,
  output logic       chg_ev,
  output logic [1:0] ev_line
);
  logic [1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        prev_q <= LN_CLOCK;
    else if (wr_valid) prev_q <= wr_line;
  end

  assign rst_ev  = wr_valid && (wr_line == LN_RESET);
  assign chg_ev  = wr_valid && (wr_line != LN_RESET) && (wr_line != prev_q);
  assign ev_line = wr_line;

  // R3: two back-to-back change events never carry the same value
  a_r3_no_repeat_event: assert property (@(posedge clk) disable iff (!rst_n)
    chg_ev |=> !(chg_ev && (ev_line == $past(ev_line))));
endmodule

// File: rtl/cmdpkt_seq.sv
// Bit counter, close detection and controller handshake.
module cmdpkt_seq
  import cmdpkt_pkg::*;
#(
  parameter int PKT_BITS = 128,
  parameter int CNT_W    = 9,
  parameter int IDX_W    = 2,
  localparam int POS_W   = $clog2(PKT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_ev,
  input  logic             chg_ev,
  input  logic [1:0]       ev_line,
  input  logic [IDX_W-1:0] ctrl_mask,
  output logic             clr_buf,
  output logic             set_en,
  output logic [POS_W-1:0] set_pos,
  output logic             pkt_valid,
  output logic [IDX_W-1:0] ctrl_idx
);
  // PKT_BITS must be a multiple of 8 and PKT_BITS+7 must fit in CNT_W-1 bits
  localparam logic signed [CNT_W-1:0] NEG1_S  = '1;
  localparam logic signed [CNT_W-1:0] ONE_S   = CNT_W'(1);
  localparam logic signed [CNT_W-1:0] DONE_S  = CNT_W'(PKT_BITS);
  localparam logic signed [CNT_W-1:0] PARK_S  = CNT_W'(PKT_BITS + 1);
  localparam logic signed [CNT_W-1:0] FLAGA_S = CNT_W'(2);
  localparam logic signed [CNT_W-1:0] FLAGB_S = CNT_W'(4);
  localparam logic signed [CNT_W-1:0] HS_S    = CNT_W'(PKT_BITS + 7);

  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0]        idx_q, idx_d;
  logic                    emit, pv_q;

  always_comb begin
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    emit    = 1'b0;
    set_en  = 1'b0;
    set_pos = cnt_q[POS_W-1:0];
    clr_buf = rst_ev;
    if (rst_ev) begin
      cnt_d = NEG1_S;
    end else if (chg_ev) begin
      if (cnt_q > DONE_S) begin
        case (ev_line)
          LN_ONE:   cnt_d = cnt_q | FLAGA_S;
          LN_CLOSE: cnt_d = cnt_q | FLAGB_S;
          LN_CLOCK: if (cnt_q == HS_S) begin
            cnt_d = cnt_q & ~(FLAGA_S | FLAGB_S);
            idx_d = IDX_W'(idx_q + 1'b1) & ctrl_mask;
          end
          default: ;
        endcase
      end else if (cnt_q == DONE_S) begin
        if (ev_line == LN_CLOSE) begin
          emit  = 1'b1;
          cnt_d = PARK_S;
        end
      end else begin
        if (ev_line == LN_ONE && !cnt_q[CNT_W-1]) set_en = 1'b1;
        else if (ev_line == LN_CLOCK)             cnt_d  = cnt_q + ONE_S;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= NEG1_S;
      idx_q <= '0;
      pv_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      pv_q  <= emit;
    end
  end

  assign pkt_valid = pv_q;
  assign ctrl_idx  = idx_q;

  a_r2_restart_counter: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ev |=> (cnt_q == NEG1_S));
  a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_ev && !chg_ev) |=> ($stable(cnt_q) && $stable(idx_q)));
  a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= NEG1_S) && (cnt_q <= HS_S));
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);
  a_r6_strobe_parks: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (cnt_q == PARK_S));
  a_r8_idx_from_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> ($past(cnt_q) == HS_S));
endmodule

// File: rtl/cmdpkt_buf.sv
// Packet byte storage with a clear and a single-bit set port.
module cmdpkt_buf #(
  parameter int PKT_BITS = 128,
  localparam int POS_W   = $clog2(PKT_BITS),
  localparam int NBYTES  = PKT_BITS / 8,
  localparam int BSEL_W  = POS_W - 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                set_en,
  input  logic [POS_W-1:0]    set_pos,
  output logic [PKT_BITS-1:0] pkt_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        byte_q <= '0;
      else if (set_en && set_pos[POS_W-1:3] == BSEL_W'(b))
        byte_q[set_pos[2:0]] <= 1'b1;
    end
    assign pkt_o[8*b +: 8] = byte_q;
  end

  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pkt_o == '0));
  a_r4_bit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pkt_o[$past(set_pos)]);
endmodule

// File: rtl/cmdpkt_rx.sv
module cmdpkt_rx #(
  parameter int PKT_BITS = 128,
  parameter int CNT_W    = 9,
  parameter int IDX_W    = 2,
  localparam int POS_W   = $clog2(PKT_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_valid,
  input  logic [1:0]          line_val,
  input  logic [IDX_W-1:0]    ctrl_mask,
  output logic [PKT_BITS-1:0] pkt_data,
  output logic                pkt_valid,
  output logic [IDX_W-1:0]    ctrl_idx
);
  logic             rst_ev, chg_ev, clr_buf, set_en;
  logic [1:0]       ev_line;
  logic [POS_W-1:0] set_pos;

  cmdpkt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .wr_valid(line_valid), .wr_line(line_val),
    .rst_ev(rst_ev), .chg_ev(chg_ev), .ev_line(ev_line)
  );

  cmdpkt_seq #(.PKT_BITS(PKT_BITS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rst_ev(rst_ev), .chg_ev(chg_ev),
    .ev_line(ev_line), .ctrl_mask(ctrl_mask), .clr_buf(clr_buf),
    .set_en(set_en), .set_pos(set_pos), .pkt_valid(pkt_valid),
    .ctrl_idx(ctrl_idx)
  );

  cmdpkt_buf #(.PKT_BITS(PKT_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr_buf), .set_en(set_en),
    .set_pos(set_pos), .pkt_o(pkt_data)
  );

  // R1: no strobe in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !pkt_valid);
endmodule

// File: tb/cmdpkt_rx_tb_top.sv
`timescale 1ns/1ps
module cmdpkt_rx_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         line_valid = 1'b0;
  logic [1:0]   line_val = 2'b11;
  logic [1:0]   ctrl_mask = 2'b11;
  logic [127:0] pkt_data;
  logic         pkt_valid;
  logic [1:0]   ctrl_idx;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  bit done = 1'b0;
  logic [1:0] exp_idx = 2'b00;

  always #2.5 clk = ~clk;

  cmdpkt_rx dut_i (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_val(line_val),
    .ctrl_mask(ctrl_mask), .pkt_data(pkt_data), .pkt_valid(pkt_valid),
    .ctrl_idx(ctrl_idx)
  );

  always @(posedge clk) if (pkt_valid) strobes++;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] v);
    @(negedge clk);
    line_valid = 1'b1;
    line_val   = v;
    @(negedge clk);
    line_valid = 1'b0;
  endtask

  // restart, then clock in all bits; leaves counter at 128
  task automatic load_bits(input logic [127:0] pat);
    put(2'b00);
    put(2'b11);
    for (int i = 0; i < 128; i++) begin
      put(pat[i] ? 2'b01 : 2'b10);
      put(2'b11);
    end
  endtask

  task automatic close_and_check(input logic [127:0] pat, input string tag);
    int s0;
    s0 = strobes;
    put(2'b10);
    chk(pkt_valid == 1'b1, {"R6 strobe ", tag}, 128'(pkt_valid), 128'd1);
    chk(pkt_data == pat, {"R4 data ", tag}, pkt_data, pat);
    @(negedge clk);
    chk(pkt_valid == 1'b0, {"R6 strobe width ", tag}, 128'(pkt_valid), 128'd0);
    chk(strobes - s0 == 1, {"R6 strobe count ", tag}, 128'(strobes - s0), 128'd1);
  endtask

  task automatic t_reset_state;
    chk(pkt_data == '0, "R1 data", pkt_data, '0);
    chk(pkt_valid == 1'b0, "R1 strobe", 128'(pkt_valid), 128'd0);
    chk(ctrl_idx == 2'b00, "R1 idx", 128'(ctrl_idx), 128'd0);
    put(2'b01);
    chk(pkt_data == '0, "R1 counter starts at -1", pkt_data, '0);
    put(2'b11);
    put(2'b01);
    chk(pkt_data == 128'd1, "R4 first bit", pkt_data, 128'd1);
    put(2'b00);
    chk(pkt_data == '0, "R2 restart clears", pkt_data, '0);
  endtask

  task automatic t_packet(input logic [127:0] pat, input string tag);
    load_bits(pat);
    chk(ctrl_idx == exp_idx, {"R8 idx during collection ", tag}, 128'(ctrl_idx), 128'(exp_idx));
    close_and_check(pat, tag);
    put(2'b01);
    chk(pkt_data == pat, {"R6 data held ", tag}, pkt_data, pat);
  endtask

  task automatic t_repeat;
    put(2'b00);
    put(2'b11); put(2'b11); put(2'b11);
    put(2'b01); put(2'b01);
    put(2'b11); put(2'b11);
    put(2'b01);
    chk(pkt_data == 128'd3, "R3 repeats ignored", pkt_data, 128'd3);
    put(2'b00); put(2'b00);
    chk(pkt_data == '0, "R2 repeated restart", pkt_data, '0);
  endtask

  task automatic t_midway_restart;
    logic [127:0] pat;
    pat = {4{32'h1234_5678}};
    put(2'b00); put(2'b11);
    for (int i = 0; i < 5; i++) begin put(2'b01); put(2'b11); end
    put(2'b00);
    chk(pkt_data == '0, "R2 restart midway", pkt_data, '0);
    load_bits(pat);
    close_and_check(pat, "after restart");
  endtask

  task automatic t_overrun;
    logic [127:0] pat;
    pat = {64'hF0F0_0000_FFFF_1234, 64'h8000_0000_0000_0002};
    load_bits(pat);
    put(2'b01); put(2'b11); put(2'b01); put(2'b11);
    chk(pkt_data == pat, "R5 no bits past end", pkt_data, pat);
    close_and_check(pat, "overrun");
  endtask

  task automatic hs_step;
    put(2'b01); put(2'b10); put(2'b11);
    exp_idx = (exp_idx + 2'd1) & ctrl_mask;
    chk(ctrl_idx == exp_idx, "R7 handshake step", 128'(ctrl_idx), 128'(exp_idx));
  endtask

  task automatic t_handshake(input logic [1:0] mask);
    logic [127:0] pat;
    pat = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    ctrl_mask = mask;
    t_packet(pat, "handshake");
    for (int k = 0; k < 5; k++) hs_step();
    put(2'b10); put(2'b11);
    chk(ctrl_idx == exp_idx, "R8 partial flags", 128'(ctrl_idx), 128'(exp_idx));
    put(2'b01); put(2'b11);
    exp_idx = (exp_idx + 2'd1) & ctrl_mask;
    chk(ctrl_idx == exp_idx, "R7 flags in other order", 128'(ctrl_idx), 128'(exp_idx));
    put(2'b00);
    chk(ctrl_idx == exp_idx, "R2 restart keeps idx", 128'(ctrl_idx), 128'(exp_idx));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_packet('1, "all ones");
    t_packet({16{8'hA5}}, "a5 bytes");
    t_packet(128'h8000_0000_0000_0001_0000_0000_0000_0080, "sparse");
    t_repeat();
    t_midway_restart();
    t_overrun();
    t_handshake(2'b11);
    t_handshake(2'b01);
    t_handshake(2'b00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule